// File: doc/BRIEF.md
# Programmable Clock Divider with Phase Slip

The block takes a fast sample clock and produces a divided clock at one of three ratios: 1, 2 or 4. A 3-bit one-hot control field picks the ratio. The field's all-zero code hands the choice to an external three-level select pin, which arrives already decoded into two bits. A status output reports the ratio that is currently in force. A change of ratio waits for the end of the divided period that is running, so the output never shows a shortened pulse.

When several converters divide the same fast clock, their divided clocks can settle at different phases. A phase-slip control lines them up. Each low-to-high transition of the slip control bit moves the divide-by-4 output earlier by exactly one input-clock period. The slip bit is synchronized into the input-clock domain and edge-detected, so holding it at a level does nothing. A soft reset leaves the ratio selection and the running divided clock alone. It only discards slip requests that arrive while it is high.

A hard reset is asserted asynchronously and released through a synchronizer. Once it is released, the divided clock starts cleanly and lines up with a known input edge.

Top module: `clk_phase_divider`

## Requirements
- R1: The field codes 001, 010 and 100 select divide-by-1, divide-by-2 and divide-by-4. div_status is one-hot: bit 0 means divide-by-1, bit 1 divide-by-2 and bit 2 divide-by-4.
- R2: With field 000 the ratio follows div_pin: 00 gives divide-by-1, 01 divide-by-2, 10 divide-by-4 and 11 divide-by-1.
- R3: Any field code other than 000, 001, 010 and 100 selects divide-by-1.
- R4: At divide-by-2 and divide-by-4, clk_div repeats every N input cycles and is high for N/2 of them, starting at an input rising edge.
- R5: At divide-by-1, clk_div follows clk_in.
- R6: A new ratio takes effect at the rising edge that ends the current divided period. No period is shorter than both the old and the new ratio.
- R7: At divide-by-4, each 0-to-1 transition of slip_ctl moves all later clk_div rising edges one input cycle earlier. Two transitions move them two cycles earlier.
- R8: At divide-by-1 and divide-by-2 a slip transition has no effect on the output phase.
- R9: Only transitions act. Holding slip_ctl high for any number of cycles produces exactly one slip.
- R10: While soft_rst is high, slip transitions are discarded. soft_rst changes neither div_status nor the clk_div phase.
- R11: While rst_n is low, clk_div is 0 and div_status is 000. After rst_n rises, clk_div first rises at the third rising edge of clk_in and then runs regularly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Fast input clock |
| rst_n | input | 1 | Asynchronous active-low hard reset, released synchronously inside |
| soft_rst | input | 1 | Soft reset; discards slip requests while high |
| div_field | input | 3 | One-hot ratio field; 000 selects pin control |
| div_pin | input | 2 | Decoded three-level select pin |
| slip_ctl | input | 1 | Phase-slip control bit; acts on a 0-to-1 transition |
| clk_div | output | 1 | Divided clock |
| div_status | output | 3 | One-hot ratio currently in force |

## Verification
The ratio selection is driven with directed field and pin settings and with random pairs of the two. The random pairs include the undefined field codes and the spare pin code, which separates the one-hot field decode from the pin fallback and the divide-by-1 default. Period and high-time measurements separate divide-by-2 from divide-by-4. Sampling clk_div in both halves of the input clock shows the divide-by-1 bypass. Phase is measured as the rising-edge position modulo the ratio. Single slips, double slips, slips at divide-by-2, a slip bit held high, and slips under soft reset each predict a different phase offset, so a wrong step, a repeated pulse or a missing mask shows up as a phase error. Ratio switches are made just after a divided rising edge so that the expected switch edge is known exactly.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  localparam int RATIO_MAX   = 4;
  localparam int RATIO_CNT_W = $clog2(RATIO_MAX);
  localparam int RATIO_LEN_W = RATIO_CNT_W + 1;

  typedef logic [2:0] ratio_oh_t;

  localparam ratio_oh_t RATIO_NONE = 3'b000;
  localparam ratio_oh_t RATIO_1    = 3'b001;
  localparam ratio_oh_t RATIO_2    = 3'b010;
  localparam ratio_oh_t RATIO_4    = 3'b100;

  // Field code 000 defers to the pin; undefined codes fall back to divide-by-1.
  function automatic ratio_oh_t decode_ratio(input logic [2:0] field, input logic [1:0] pin);
    ratio_oh_t r;
    case (field)
      3'b000: begin
        case (pin)
          2'b01:   r = RATIO_2;
          2'b10:   r = RATIO_4;
          default: r = RATIO_1;
        endcase
      end
      3'b010:  r = RATIO_2;
      3'b100:  r = RATIO_4;
      default: r = RATIO_1;
    endcase
    return r;
  endfunction

  // Period length in input cycles; the idle code after reset counts as one.
  function automatic logic [RATIO_LEN_W-1:0] ratio_len(input ratio_oh_t r);
    logic [RATIO_LEN_W-1:0] n;
    case (r)
      RATIO_2: n = RATIO_LEN_W'(2);
      RATIO_4: n = RATIO_LEN_W'(4);
      default: n = RATIO_LEN_W'(1);
    endcase
    return n;
  endfunction

endpackage

// File: rtl/cdiv_rst_sync.sv
module cdiv_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_n_i,
  output logic srst_n_o
);

  logic [STAGES-1:0] chain_q, chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge arst_n_i) begin
    if (!arst_n_i) chain_q <= '0;
    else           chain_q <= chain_d;
  end

  assign srst_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/cdiv_slip_detect.sv
module cdiv_slip_detect #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic soft_rst_i,
  input  logic slip_ctl_i,
  output logic slip_pulse_o
);

  logic [STAGES-1:0] sync_q, sync_d;
  logic              seen_q, seen_d;
  logic              rise;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], slip_ctl_i};
    seen_d = sync_q[STAGES-1];
    rise   = sync_q[STAGES-1] && !seen_q;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sync_q <= '0;
      seen_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      seen_q <= seen_d;
    end
  end

  // The edge history keeps tracking during soft reset, so its release cannot fire a slip.
  assign slip_pulse_o = rise && !soft_rst_i;

  p_single_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    slip_pulse_o |=> !slip_pulse_o);

endmodule

// File: rtl/cdiv_ratio_sel.sv
module cdiv_ratio_sel
  import clkdiv_pkg::*;
(
  input  logic [2:0] field_i,
  input  logic [1:0] pin_i,
  output ratio_oh_t  req_o
);

  always_comb begin
    req_o = decode_ratio(field_i, pin_i);
  end

endmodule

// File: rtl/cdiv_core.sv
module cdiv_core
  import clkdiv_pkg::*;
#(
  parameter int CNT_W = RATIO_CNT_W
) (
  input  logic      clk_i,
  input  logic      rst_n_i,
  input  ratio_oh_t req_ratio_i,
  input  logic      slip_pulse_i,
  output ratio_oh_t active_o,
  output logic      div_q_o
);

  localparam int LEN_W = CNT_W + 1;

  ratio_oh_t        active_q, active_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             out_q, out_d;
  logic [LEN_W-1:0] len_cur, len_nxt, step, sum;
  logic             slip_eff, wrap, restart;

  always_comb begin
    len_cur  = LEN_W'(ratio_len(active_q));
    slip_eff = slip_pulse_i && (active_q == RATIO_4);
    step     = slip_eff ? LEN_W'(2) : LEN_W'(1);
    sum      = {1'b0, cnt_q} + step;
    wrap     = (active_q == RATIO_NONE) || (sum >= len_cur);
    restart  = (active_q == RATIO_NONE) || (req_ratio_i != active_q);
    active_d = active_q;
    cnt_d    = CNT_W'(sum);
    if (wrap) begin
      active_d = req_ratio_i;
      cnt_d    = restart ? '0 : CNT_W'(sum - len_cur);
    end
    len_nxt = LEN_W'(ratio_len(active_d));
    out_d   = (len_nxt == LEN_W'(1)) ? 1'b1 : ({1'b0, cnt_d} < (len_nxt >> 1));
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      active_q <= RATIO_NONE;
      cnt_q    <= '0;
      out_q    <= 1'b0;
    end else begin
      active_q <= active_d;
      cnt_q    <= cnt_d;
      out_q    <= out_d;
    end
  end

  assign active_o = active_q;
  assign div_q_o  = out_q;

  p_count_range_r4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (active_q != RATIO_NONE) |-> ({1'b0, cnt_q} < LEN_W'(ratio_len(active_q))));

  p_switch_clean_r6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (active_q != $past(active_q)) |-> (cnt_q == '0 && out_q));

  p_slip_step_r7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (slip_pulse_i && active_q == RATIO_4 && req_ratio_i == RATIO_4)
      |=> (cnt_q == CNT_W'($past(cnt_q) + CNT_W'(2))));

  p_slip_ignored_r8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (active_q == RATIO_2 && req_ratio_i == RATIO_2)
      |=> (cnt_q == ($past(cnt_q) ^ CNT_W'(1))));

endmodule

// File: rtl/clk_phase_divider.sv
module clk_phase_divider
  import clkdiv_pkg::*;
#(
  parameter int RST_STAGES  = 2,
  parameter int SLIP_STAGES = 2
) (
  input  logic       clk_in,
  input  logic       rst_n,
  input  logic       soft_rst,
  input  logic [2:0] div_field,
  input  logic [1:0] div_pin,
  input  logic       slip_ctl,
  output logic       clk_div,
  output logic [2:0] div_status
);

  logic      rst_sync_n;
  logic      slip_pulse;
  ratio_oh_t req_ratio;
  ratio_oh_t active;
  logic      div_q;

  cdiv_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk_i    (clk_in),
    .arst_n_i (rst_n),
    .srst_n_o (rst_sync_n)
  );

  cdiv_slip_detect #(.STAGES(SLIP_STAGES)) u_slip (
    .clk_i        (clk_in),
    .rst_n_i      (rst_sync_n),
    .soft_rst_i   (soft_rst),
    .slip_ctl_i   (slip_ctl),
    .slip_pulse_o (slip_pulse)
  );

  cdiv_ratio_sel u_sel (
    .field_i (div_field),
    .pin_i   (div_pin),
    .req_o   (req_ratio)
  );

  cdiv_core #(.CNT_W(RATIO_CNT_W)) u_core (
    .clk_i        (clk_in),
    .rst_n_i      (rst_sync_n),
    .req_ratio_i  (req_ratio),
    .slip_pulse_i (slip_pulse),
    .active_o     (active),
    .div_q_o      (div_q)
  );

  // The select register changes only on a rising input edge where both paths are high.
  assign clk_div    = (active == RATIO_1) ? clk_in : div_q;
  assign div_status = active;

  p_status_onehot_r1: assert property (@(posedge clk_in) disable iff (!rst_sync_n)
    $onehot0(div_status));

  p_reset_quiet_r11: assert property (@(posedge clk_in)
    !rst_n |-> (clk_div == 1'b0 && div_status == RATIO_NONE));

endmodule

// File: tb/tb_clk_phase_divider.sv
`timescale 1ns/1ps
module tb_clk_phase_divider;

  logic       clk;
  logic       rst_n;
  logic       soft_rst;
  logic [2:0] div_field;
  logic [1:0] div_pin;
  logic       slip_ctl;
  logic       clk_div;
  logic [2:0] div_status;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  int cyc       = 0;
  int last_rise = -1;
  int last_int  = 0;
  int last_high = 0;
  int run       = 0;
  int n_rises   = 0;
  int min_int   = 1000;
  bit prev_v    = 0;
  bit hs        = 0;
  bit low_s     = 0;

  clk_phase_divider dut (
    .clk_in     (clk),
    .rst_n      (rst_n),
    .soft_rst   (soft_rst),
    .div_field  (div_field),
    .div_pin    (div_pin),
    .slip_ctl   (slip_ctl),
    .clk_div    (clk_div),
    .div_status (div_status)
  );

  initial begin
    clk = 1'b0;
    forever #2.5 clk = ~clk;
  end

  // High-phase monitor: one sample per input cycle, 1 ns after the rising edge.
  always @(posedge clk) begin
    #1;
    cyc++;
    hs = clk_div;
    if (clk_div && !prev_v) begin
      if (last_rise >= 0) begin
        last_int = cyc - last_rise;
        if (last_int < min_int) min_int = last_int;
      end
      last_rise = cyc;
      n_rises++;
    end
    if (clk_div) run++;
    else if (prev_v) begin
      last_high = run;
      run = 0;
    end
    prev_v = clk_div;
  end

  always @(negedge clk) begin
    #1;
    low_s = clk_div;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_ratio(input logic [2:0] f, input logic [1:0] p);
    case (f)
      3'b000: begin
        case (p)
          2'b01:   return 2;
          2'b10:   return 4;
          default: return 1;
        endcase
      end
      3'b010:  return 2;
      3'b100:  return 4;
      default: return 1;
    endcase
  endfunction

  function automatic int exp_status(input int n);
    return (n == 1) ? 1 : (n == 2) ? 2 : 4;
  endfunction

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_rise(output int r);
    int n0;
    n0 = n_rises;
    while (n_rises == n0) @(negedge clk);
    r = last_rise;
  endtask

  task automatic set_mode(input logic [2:0] f, input logic [1:0] p);
    @(negedge clk);
    div_field = f;
    div_pin   = p;
    cycles(14);
  endtask

  task automatic check_mode(input string tag);
    int n;
    n = exp_ratio(div_field, div_pin);
    chk(div_status == 3'(exp_status(n)), {tag, " status"}, int'(div_status), exp_status(n));
    if (n == 1) begin
      chk(hs == 1'b1 && low_s == 1'b0, {tag, " R5 follows clk_in"}, {hs, low_s}, 2);
    end else begin
      chk(last_int == n, {tag, " R4 period"}, last_int, n);
      chk(last_high == n / 2, {tag, " R4 high time"}, last_high, n / 2);
    end
  endtask

  task automatic slip_once();
    @(negedge clk);
    slip_ctl = 1'b1;
    cycles(5);
    slip_ctl = 1'b0;
    cycles(5);
  endtask

  task automatic phase_now(input int n, output int ph);
    int r;
    wait_rise(r);
    wait_rise(r);
    ph = r % n;
  endtask

  task automatic hard_reset_and_check(input int n, input string tag);
    int c0, r1, r2;
    @(negedge clk);
    rst_n = 1'b0;
    cycles(3);
    chk(clk_div == 1'b0 && low_s == 1'b0, {tag, " R11 output low in reset"}, clk_div, 0);
    chk(div_status == 3'b000, {tag, " R11 status in reset"}, int'(div_status), 0);
    last_rise = -1;
    n_rises   = 0;
    @(negedge clk);
    c0 = cyc;
    rst_n = 1'b1;
    wait_rise(r1);
    chk(r1 == c0 + 3, {tag, " R11 first rise"}, r1 - c0, 3);
    wait_rise(r2);
    chk(r2 == r1 + n, {tag, " R11 second rise"}, r2 - r1, n);
  endtask

  initial begin
    int r0, r1, r2, p0, p1, seed;
    rst_n     = 1'b1;
    soft_rst  = 1'b0;
    div_field = 3'b000;
    div_pin   = 2'b10;
    slip_ctl  = 1'b0;
    seed      = $urandom(97);
    #1 rst_n  = 1'b0;

    // Reset state and start-up alignment with the pin selecting divide-by-4 (R2, R11).
    hard_reset_and_check(4, "startup");
    cycles(10);
    check_mode("R2 pin 10");

    set_mode(3'b001, 2'b10); check_mode("R1 field 001");
    set_mode(3'b010, 2'b00); check_mode("R1 field 010");
    set_mode(3'b100, 2'b00); check_mode("R1 field 100");
    set_mode(3'b000, 2'b01); check_mode("R2 pin 01");
    set_mode(3'b000, 2'b11); check_mode("R2 pin 11");
    set_mode(3'b111, 2'b10); check_mode("R3 field 111");
    set_mode(3'b011, 2'b01); check_mode("R3 field 011");

    // R6: switch from 4 to 2 just after a rise, then from 2 back to 4.
    set_mode(3'b100, 2'b00);
    min_int = 1000;
    wait_rise(r0);
    div_field = 3'b010;
    wait_rise(r1);
    chk(r1 == r0 + 4, "R6 4->2 switch edge", r1 - r0, 4);
    chk(div_status == 3'b010, "R6 status at switch", int'(div_status), 2);
    wait_rise(r2);
    chk(r2 == r1 + 2, "R6 first short period", r2 - r1, 2);
    wait_rise(r0);
    div_field = 3'b100;
    wait_rise(r1);
    chk(r1 == r0 + 2, "R6 2->4 switch edge", r1 - r0, 2);
    wait_rise(r2);
    chk(r2 == r1 + 4, "R6 first long period", r2 - r1, 4);
    chk(min_int >= 2, "R6 no runt period", min_int, 2);

    // R7: single and double slips at divide-by-4.
    phase_now(4, p0);
    slip_once();
    cycles(6);
    phase_now(4, p1);
    chk(p1 == (p0 + 3) % 4, "R7 single slip phase", p1, (p0 + 3) % 4);
    slip_once();
    slip_once();
    cycles(6);
    phase_now(4, p0);
    chk(p0 == (p1 + 2) % 4, "R7 double slip phase", p0, (p1 + 2) % 4);
    cycles(10);
    check_mode("R7 after slips");

    // R8: slips at divide-by-2 and divide-by-1 are ignored.
    set_mode(3'b010, 2'b00);
    phase_now(2, p0);
    slip_once();
    slip_once();
    slip_once();
    cycles(6);
    phase_now(2, p1);
    chk(p1 == p0, "R8 divide-by-2 phase kept", p1, p0);
    check_mode("R8 divide-by-2 shape");
    set_mode(3'b001, 2'b00);
    slip_once();
    cycles(4);
    check_mode("R8 divide-by-1");

    // R9: a held-high slip bit acts once.
    set_mode(3'b100, 2'b00);
    phase_now(4, p0);
    @(negedge clk);
    slip_ctl = 1'b1;
    cycles(12);
    phase_now(4, p1);
    chk(p1 == (p0 + 3) % 4, "R9 one slip on hold", p1, (p0 + 3) % 4);
    cycles(30);
    phase_now(4, p0);
    chk(p0 == p1, "R9 no repeat while held", p0, p1);
    slip_ctl = 1'b0;
    cycles(6);

    // R10: a slip transition under soft reset is discarded.
    phase_now(4, p0);
    @(negedge clk);
    soft_rst = 1'b1;
    slip_ctl = 1'b1;
    cycles(8);
    soft_rst = 1'b0;
    cycles(10);
    phase_now(4, p1);
    chk(p1 == p0, "R10 phase kept under soft reset", p1, p0);
    chk(div_status == 3'b100, "R10 status kept", int'(div_status), 4);
    slip_ctl = 1'b0;
    cycles(6);

    // Random mode changes, with random slips at divide-by-4.
    for (int i = 0; i < 40; i++) begin
      logic [2:0] f;
      logic [1:0] p;
      f = 3'($urandom % 8);
      p = 2'($urandom % 4);
      set_mode(f, p);
      check_mode("R1 R2 R3 random");
      if (exp_ratio(f, p) == 4 && ($urandom % 2) == 1) begin
        phase_now(4, p0);
        slip_once();
        cycles(6);
        phase_now(4, p1);
        chk(p1 == (p0 + 3) % 4, "R7 random slip", p1, (p0 + 3) % 4);
      end
    end

    // R11: hard reset in the middle of a divide-by-2 run.
    set_mode(3'b010, 2'b00);
    hard_reset_and_check(2, "midrun");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

endmodule